// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer with Loop Counter

This block picks the address of the next microinstruction in a microprogrammed control unit. A separate decoder drives its control lines each cycle. A four-way multiplexer chooses the next address from one of four sources:

- the microprogram counter, which gives sequential flow;
- the top of a small return stack, which gives subroutine returns and loops back to a stored start;
- a shared address bus;
- a start/alternate address register.

Three sources can drive the shared bus, each through its own active-low enable: the branch/count field of the pipeline register, the opcode mapping address and a vector address. The register, the counter and the stack all take their load values from this bus or from the counter value.

The same microword field can carry a branch target in one instruction and a repeat count in another. A down-counter loads from the shared bus and counts down toward zero. Its zero status goes to the external condition test path, so loops can run a fixed number of times. The return stack has four entries and a two-bit pointer. It wraps on overflow and gives no full indication.

Top module: `mseq_core`

## Requirements
- R1: While `rst` is high, `next_addr` is 0 whatever the select and bus inputs are. After the first clock edge with `rst` high, `upc` is 1 and `cnt_zero` is 1.
- R2: `sel` picks the next address: 2'b00 gives the microprogram counter, 2'b01 gives the stack top, 2'b10 gives the shared bus and 2'b11 gives the start register.
- R3: The shared bus carries `br_field` when `br_oe_n` is 0, `map_addr` when `map_oe_n` is 0 and `vec_addr` when `vec_oe_n` is 0. At most one enable is low at a time. With none low, the bus reads 0.
- R4: On every rising edge, `upc` takes the value of `next_addr` plus one, modulo 2^AW. Selecting the counter therefore steps through consecutive addresses.
- R5: A push (`file_en_n`=0, `push_pop`=1) writes the current `upc` value. The following cycle sees that value on the stack top.
- R6: A pop (`file_en_n`=0, `push_pop`=0) presents the current top in the same cycle and then steps the pointer back. Entries come off in last-in, first-out order. With `file_en_n`=1 the stack does not change.
- R7: A fifth push with no pop in between wraps the pointer from entry 3 to entry 0 and overwrites the oldest entry, with no flag. Popping then yields the fifth, fourth, third and second values, followed by the fifth value again.
- R8: With `cnt_ld_n`=0 the counter loads from the shared bus, and load takes priority over decrement.
- R9: With `cnt_ld_n`=1 and `cnt_dec_n`=0 the counter drops by one. A counter already at zero stays at zero.
- R10: `cnt_zero` is 1 exactly when the counter holds 0.
- R11: With `reg_ld_n`=0 the start register loads from the shared bus. With `reg_ld_n`=1 it keeps its value.
- R12: A pop when no entry is live still reads the entry below the pointer (index 3 when the pointer is 0) and returns whatever that entry last held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_field | input | AW | Pipeline branch address or loop count |
| map_addr | input | AW | Opcode mapping address |
| vec_addr | input | AW | Vector address |
| br_oe_n | input | 1 | Drives br_field onto the shared bus, active low |
| map_oe_n | input | 1 | Drives map_addr onto the shared bus, active low |
| vec_oe_n | input | 1 | Drives vec_addr onto the shared bus, active low |
| sel | input | 2 | Next-address source select |
| file_en_n | input | 1 | Stack operation enable, active low |
| push_pop | input | 1 | 1 = push, 0 = pop |
| cnt_ld_n | input | 1 | Counter load, active low |
| cnt_dec_n | input | 1 | Counter decrement, active low |
| reg_ld_n | input | 1 | Start register load, active low |
| next_addr | output | AW | Address of the next microinstruction |
| upc | output | AW | Microprogram counter value |
| cnt_zero | output | 1 | Counter equals zero |

## Verification
The bench fills the stack with five pushes and then drains it with six pops. A design that saturated the pointer, raised a hidden full condition or overwrote the wrong entry would return values out of the expected 5-4-3-2-5-4 order. It also decrements the counter past zero and asserts load together with decrement. A counter that wrapped to all ones, or that let decrement win, would leave `cnt_zero` wrong. Finally, it applies each bus enable alone and then none of them, and holds the register load off while the bus changes. Any leakage between bus sources, or a register that loads without its enable, shows up on `next_addr`.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        SEL_UPC   = 2'b00,
        SEL_STACK = 2'b01,
        SEL_BUS   = 2'b10,
        SEL_ALT   = 2'b11
    } nsel_e;

endpackage

// File: rtl/mseq_stack.sv
module mseq_stack #(
    parameter int AW    = 12,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_n,
    input  logic          push,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0]              wp;
        logic [DEPTH-1:0][AW-1:0]   mem;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (!en_n) begin
            if (push) begin
                stk_d.mem[stk_q.wp] = din;
                stk_d.wp            = stk_q.wp + PW'(1);
            end else begin
                stk_d.wp            = stk_q.wp - PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // top of stack sits one below the write pointer (wraps)
    assign top = stk_q.mem[stk_q.wp - PW'(1)];

    // R5: a pushed value is on top in the following cycle
    a_r5_push_on_top: assert property (@(posedge clk) disable iff (rst)
        (!en_n && push) |=> (top == $past(din)));

    // R6: without a stack operation the top is unchanged
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        en_n |=> $stable(top));

endmodule

// File: rtl/mseq_loopctr.sv
module mseq_loopctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_n,
    input  logic         dec_n,
    input  logic [W-1:0] din,
    output logic         zero
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (!ld_n) begin
            ctr_d.cnt = din;
        end else if (!dec_n && (ctr_q.cnt != '0)) begin
            ctr_d.cnt = ctr_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign zero = (ctr_q.cnt == '0);

    // R9: decrementing at zero keeps the counter at zero
    a_r9_floor_at_zero: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !dec_n && zero) |=> zero);

    // R8: a load decides zero status from the loaded value
    a_r8_load_sets_status: assert property (@(posedge clk) disable iff (rst)
        (!ld_n) |=> (zero == ($past(din) == '0)));

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
#(
    parameter int AW          = 12,
    parameter int STACK_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] br_field,
    input  logic [AW-1:0] map_addr,
    input  logic [AW-1:0] vec_addr,
    input  logic          br_oe_n,
    input  logic          map_oe_n,
    input  logic          vec_oe_n,
    input  logic [1:0]    sel,
    input  logic          file_en_n,
    input  logic          push_pop,
    input  logic          cnt_ld_n,
    input  logic          cnt_dec_n,
    input  logic          reg_ld_n,
    output logic [AW-1:0] next_addr,
    output logic [AW-1:0] upc,
    output logic          cnt_zero
);
    localparam int NSRC = 3;

    typedef struct packed {
        logic [AW-1:0] upc;
        logic [AW-1:0] alt;
    } core_t;

    core_t core_d, core_q;

    logic [AW-1:0]            bus;
    logic [AW-1:0]            stack_top;
    logic [NSRC-1:0]          drv_en;
    logic [NSRC-1:0][AW-1:0]  drv_val;
    logic [AW-1:0]            mux_out;

    assign drv_en  = {~vec_oe_n, ~map_oe_n, ~br_oe_n};
    assign drv_val = {vec_addr, map_addr, br_field};

    // wired-OR model of the shared, enabled bus
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (drv_en[i]) begin
                bus = bus | drv_val[i];
            end
        end
    end

    always_comb begin
        unique case (nsel_e'(sel))
            SEL_UPC:   mux_out = core_q.upc;
            SEL_STACK: mux_out = stack_top;
            SEL_BUS:   mux_out = bus;
            SEL_ALT:   mux_out = core_q.alt;
            default:   mux_out = core_q.upc;
        endcase
    end

    assign next_addr = rst ? '0 : mux_out;

    always_comb begin
        core_d     = core_q;
        core_d.upc = next_addr + AW'(1);
        if (!reg_ld_n) begin
            core_d.alt = bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.upc <= AW'(1);
            core_q.alt <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign upc = core_q.upc;

    mseq_stack #(
        .AW    (AW),
        .DEPTH (STACK_DEPTH)
    ) stack_i (
        .clk  (clk),
        .rst  (rst),
        .en_n (file_en_n),
        .push (push_pop),
        .din  (core_q.upc),
        .top  (stack_top)
    );

    mseq_loopctr #(
        .W (AW)
    ) ctr_i (
        .clk   (clk),
        .rst   (rst),
        .ld_n  (cnt_ld_n),
        .dec_n (cnt_dec_n),
        .din   (bus),
        .zero  (cnt_zero)
    );

    // R3: never more than one source enabled onto the shared bus
    a_r3_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_en));

    // R4: the counter register follows the issued address plus one
    a_r4_upc_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (upc == $past(next_addr) + AW'(1)));

    // R11: without a load strobe the start register keeps its value
    a_r11_alt_holds: assert property (@(posedge clk) disable iff (rst)
        reg_ld_n |=> $stable(core_q.alt));

endmodule

// File: tb/mseq_core_tb.sv
module mseq_core_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] br_field, map_addr, vec_addr;
    logic          br_oe_n, map_oe_n, vec_oe_n;
    logic [1:0]    sel;
    logic          file_en_n, push_pop, cnt_ld_n, cnt_dec_n, reg_ld_n;
    logic [AW-1:0] next_addr, upc;
    logic          cnt_zero;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mseq_core #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst),
        .br_field(br_field), .map_addr(map_addr), .vec_addr(vec_addr),
        .br_oe_n(br_oe_n), .map_oe_n(map_oe_n), .vec_oe_n(vec_oe_n),
        .sel(sel), .file_en_n(file_en_n), .push_pop(push_pop),
        .cnt_ld_n(cnt_ld_n), .cnt_dec_n(cnt_dec_n), .reg_ld_n(reg_ld_n),
        .next_addr(next_addr), .upc(upc), .cnt_zero(cnt_zero)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        br_oe_n = 1; map_oe_n = 1; vec_oe_n = 1;
        sel = 2'b00; file_en_n = 1; push_pop = 0;
        cnt_ld_n = 1; cnt_dec_n = 1; reg_ld_n = 1;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        idle();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        idle();
        rst = 1;
        br_field = 12'h055; br_oe_n = 0; sel = 2'b10;
        tick();
        rst = 1; br_oe_n = 0; sel = 2'b10; settle();
        chk("R1 next_addr in reset", next_addr, 12'h000);
        chk("R1 upc after reset edge", upc, 12'h001);
        chk("R1 cnt_zero after reset", AW'(cnt_zero), AW'(1));
        tick();
        rst = 0;
    endtask

    task automatic t_continue();
        br_field = 12'h100; br_oe_n = 0; sel = 2'b10; settle();
        chk("R2 bus select", next_addr, 12'h100);
        tick();
        chk("R4 upc after jump", upc, 12'h101);
        sel = 2'b00; settle();
        chk("R4 continue", next_addr, 12'h101);
        tick();
        settle();
        chk("R4 continue again", next_addr, 12'h102);
        tick();
    endtask

    task automatic t_bus();
        map_addr = 12'h2A5; vec_addr = 12'h3C3; br_field = 12'h0F0;
        map_oe_n = 0; sel = 2'b10; settle();
        chk("R3 map on bus", next_addr, 12'h2A5);
        tick();
        vec_oe_n = 0; sel = 2'b10; settle();
        chk("R3 vector on bus", next_addr, 12'h3C3);
        tick();
        sel = 2'b10; settle();
        chk("R3 no driver reads zero", next_addr, 12'h000);
        tick();
    endtask

    task automatic t_reg();
        br_field = 12'h3A0; br_oe_n = 0; reg_ld_n = 0; settle();
        tick();
        sel = 2'b11; settle();
        chk("R11 register load", next_addr, 12'h3A0);
        tick();
        br_field = 12'h111; br_oe_n = 0; settle();
        tick();
        sel = 2'b11; settle();
        chk("R11 register holds", next_addr, 12'h3A0);
        tick();
    endtask

    task automatic push_val(input logic [AW-1:0] v);
        br_field = v - AW'(1); br_oe_n = 0; sel = 2'b10; settle();
        tick();
        file_en_n = 0; push_pop = 1; settle();
        tick();
    endtask

    task automatic pop_chk(input string req, input logic [AW-1:0] exp);
        sel = 2'b01; file_en_n = 0; push_pop = 0; settle();
        chk(req, next_addr, exp);
        tick();
    endtask

    task automatic t_stack();
        push_val(12'h011);
        push_val(12'h022);
        file_en_n = 1; settle();
        tick();
        sel = 2'b01; settle();
        chk("R6 idle keeps top", next_addr, 12'h022);
        tick();
        pop_chk("R5 R6 pop newest", 12'h022);
        pop_chk("R6 pop older", 12'h011);
    endtask

    task automatic t_wrap();
        push_val(12'h041);
        push_val(12'h042);
        push_val(12'h043);
        push_val(12'h044);
        push_val(12'h045);
        pop_chk("R7 pop after wrap 1", 12'h045);
        pop_chk("R7 pop after wrap 2", 12'h044);
        pop_chk("R7 pop after wrap 3", 12'h043);
        pop_chk("R7 pop after wrap 4", 12'h042);
        pop_chk("R7 overwritten oldest", 12'h045);
        pop_chk("R12 stale entry", 12'h044);
    endtask

    task automatic t_counter();
        br_field = 12'h003; br_oe_n = 0; cnt_ld_n = 0; settle();
        tick();
        settle();
        chk("R8 R10 loaded 3", AW'(cnt_zero), AW'(0));
        for (int i = 0; i < 3; i++) begin
            cnt_dec_n = 0; settle();
            tick();
            settle();
            chk("R9 R10 countdown", AW'(cnt_zero), (i == 2) ? AW'(1) : AW'(0));
        end
        cnt_dec_n = 0; settle();
        tick();
        settle();
        chk("R9 floor at zero", AW'(cnt_zero), AW'(1));
        br_field = 12'h001; br_oe_n = 0; cnt_ld_n = 0; cnt_dec_n = 0; settle();
        tick();
        settle();
        chk("R8 load beats decrement", AW'(cnt_zero), AW'(0));
        cnt_dec_n = 0; settle();
        tick();
        settle();
        chk("R9 one to zero", AW'(cnt_zero), AW'(1));
        map_addr = 12'h002; map_oe_n = 0; cnt_ld_n = 0; settle();
        tick();
        cnt_dec_n = 0; settle();
        tick();
        settle();
        chk("R8 map load then one step", AW'(cnt_zero), AW'(0));
        br_field = 12'h000; br_oe_n = 0; cnt_ld_n = 0; settle();
        tick();
        settle();
        chk("R10 load zero", AW'(cnt_zero), AW'(1));
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        br_field = '0; map_addr = '0; vec_addr = '0;
        rst = 1;
        idle();
        #5;
        t_reset();
        t_continue();
        t_bus();
        t_reg();
        t_stack();
        t_wrap();
        t_counter();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule